// File: doc/BRIEF.md
# Block-Floating-Point Radix-2 Butterfly

This block is the arithmetic core of one radix-2 decimation-in-time FFT pass. Each accepted beat carries two complex samples, a top operand (x0, y0) and a bottom operand (x1, y1), plus a twiddle presented as its cosine C and its negated sine (−S). The bottom operand is rotated by the twiddle, A = C·x1 − (−S)·y1 and B = C·y1 + (−S)·x1, and the pair is formed as x0 + A, y0 + B, x0 − A, y0 − B. Samples are signed fractional Q1.15 values; products are rounded back to the data grid before the sum and difference, and results that leave the Q1.15 range are clipped.

A stage controller drives block-floating-point scaling around the block. It pulses `stage_start` before each pass and says with `scale_in` whether that pass should halve its operands. The block records the choice for the pass, counts the halvings in a block exponent, and raises a sticky headroom flag as soon as any output component reaches a quarter of full scale. One butterfly output can grow to roughly three times its largest input, so that flag tells the controller to request halving on the next pass.

A two-state sequencer governs the block. `ST_IDLE` is the state after reset, and beats are ignored there. The transition T_START (`stage_start` in `ST_IDLE`) enters `ST_RUN`. In `ST_RUN`, the transition T_RESTART (`stage_start` again) stays in `ST_RUN` and begins a new pass. No transition leaves `ST_RUN` except reset.

Top module: `bfp_butterfly`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `valid_out`, all four results, `headroom_risk` and `blk_exp` read zero, and the sequencer is in `ST_IDLE`.
- R2: A beat accepted at a rising edge (`valid_in` high in `ST_RUN`) appears with `valid_out` high after exactly three rising edges, one result per accepted beat, in order, with a new beat accepted on every cycle.
- R3: With R = 2^14 and an arithmetic right shift of 15, A = (C·x1_re − NS·x1_im + R) >>> 15 and B = (C·x1_im + NS·x1_re + R) >>> 15. The results are y0_re = x0_re + A, y0_im = x0_im + B, y1_re = x0_re − A and y1_im = x0_im − B.
- R4: Any result outside the range −32768..32767 is clipped to the nearest bound.
- R5: `valid_in` is ignored in `ST_IDLE`, and no `valid_out` follows it.
- R6: `stage_start` records `scale_in` as the halving mode for the pass it opens. Changes on `scale_in` at other times have no effect on results.
- R7: In a pass opened with halving, all four operand components (x0_re, x0_im, x1_re, x1_im) are arithmetically shifted right by one (rounding toward minus infinity) before R3 applies. The twiddle is never shifted.
- R8: `headroom_risk` rises in the same cycle as the first valid result with any component ≥ 8192 or ≤ −8192, and it stays high until the next `stage_start`.
- R9: The cycle after `stage_start`, `headroom_risk` reads zero. The clear wins over a set in the same cycle.
- R10: Each `stage_start` with `scale_in` high adds one to `blk_exp`, which saturates at 2^EXPW − 1. `blk_exp` changes at no other time except reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| stage_start | input | 1 | Single-cycle pulse that opens a pass |
| scale_in | input | 1 | Halving request, sampled with `stage_start` |
| valid_in | input | 1 | Operands and twiddle valid this cycle |
| x0_re | input | DW | Top operand, real part (Q1.15) |
| x0_im | input | DW | Top operand, imaginary part |
| x1_re | input | DW | Bottom operand, real part |
| x1_im | input | DW | Bottom operand, imaginary part |
| tw_cos | input | DW | Twiddle cosine C |
| tw_nsin | input | DW | Twiddle negated sine (−S) |
| valid_out | output | 1 | Results valid this cycle |
| y0_re | output | DW | Sum output, real part |
| y0_im | output | DW | Sum output, imaginary part |
| y1_re | output | DW | Difference output, real part |
| y1_im | output | DW | Difference output, imaginary part |
| headroom_risk | output | 1 | Sticky flag: a result of this pass reached a quarter of full scale |
| blk_exp | output | EXPW | Count of halved passes |

## Verification
The embedded properties assume that `stage_start` is a single-cycle pulse, that it is never raised while a beat is still in the three-stage pipeline, and that it never arrives together with `valid_in`. Under these conditions every flag change and every halving decision belongs to one pass only. The stimulus drains the pipeline for several idle cycles before every pass boundary, and it sends beats only between boundaries. Random operands cover the full Q1.15 range and hit the clipping bounds, and `scale_in` toggles at random inside passes to show that only the value at the boundary counts. Directed beats cover the extreme operand corners, the exact latency, and the sticky flag.

// File: rtl/bfp_pkg.sv
package bfp_pkg;

    // Pass sequencer states.
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } stage_state_e;

endpackage

// File: rtl/bfp_stage_ctrl.sv
module bfp_stage_ctrl
    import bfp_pkg::*;
#(
    parameter int EXPW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stage_start,
    input  logic            scale_in,
    input  logic            risk_hit,
    output logic            running,
    output logic            scale_mode,
    output logic            headroom_risk,
    output logic [EXPW-1:0] blk_exp
);

    localparam logic [EXPW-1:0] EXP_MAX = '1;

    stage_state_e state_q, state_d;

    // Next-state decode (T_START from idle, T_RESTART within run).
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (stage_start) state_d = ST_RUN;
            ST_RUN:  state_d = ST_RUN;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Per-pass outputs: halving mode, sticky flag, exponent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scale_mode    <= 1'b0;
            headroom_risk <= 1'b0;
            blk_exp       <= '0;
        end else if (stage_start) begin
            scale_mode    <= scale_in;
            headroom_risk <= 1'b0;
            if (scale_in && (blk_exp != EXP_MAX)) blk_exp <= blk_exp + 1'b1;
        end else if (risk_hit) begin
            headroom_risk <= 1'b1;
        end
    end

    assign running = (state_q == ST_RUN);

    // R9: a pass boundary always leaves the flag clear.
    a_r9_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        stage_start |=> !headroom_risk);

    // R8: the flag holds until the next boundary.
    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (headroom_risk && !stage_start) |=> headroom_risk);

    // R10: one step per halved pass below saturation.
    a_r10_exp_step: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_start && scale_in && (blk_exp != EXP_MAX)) |=> (blk_exp == $past(blk_exp) + 1'b1));

    // R10: no change between boundaries.
    a_r10_exp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !stage_start |=> $stable(blk_exp));

endmodule

// File: rtl/bfp_rotate.sv
module bfp_rotate #(
    parameter int DW = 16,
    parameter int AW = DW + 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 accept,
    input  logic                 scale_mode,
    input  logic signed [DW-1:0] x0_re,
    input  logic signed [DW-1:0] x0_im,
    input  logic signed [DW-1:0] x1_re,
    input  logic signed [DW-1:0] x1_im,
    input  logic signed [DW-1:0] tw_cos,
    input  logic signed [DW-1:0] tw_nsin,
    output logic                 rot_valid,
    output logic signed [AW-1:0] rot_re,
    output logic signed [AW-1:0] rot_im,
    output logic signed [DW-1:0] x0_re_d,
    output logic signed [DW-1:0] x0_im_d
);

    localparam int MW   = 2 * DW;
    localparam int PW   = MW + 2;
    localparam int FRAC = DW - 1;
    localparam logic signed [PW-1:0] RND = PW'(1) <<< (FRAC - 1);

    // Stage 1: capture, with optional halving of the operands.
    logic                 s1_valid;
    logic signed [DW-1:0] s1_x0r, s1_x0i, s1_x1r, s1_x1i, s1_c, s1_ns;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_x0r   <= '0;
            s1_x0i   <= '0;
            s1_x1r   <= '0;
            s1_x1i   <= '0;
            s1_c     <= '0;
            s1_ns    <= '0;
        end else begin
            s1_valid <= accept;
            if (accept) begin
                s1_x0r <= scale_mode ? (x0_re >>> 1) : x0_re;
                s1_x0i <= scale_mode ? (x0_im >>> 1) : x0_im;
                s1_x1r <= scale_mode ? (x1_re >>> 1) : x1_re;
                s1_x1i <= scale_mode ? (x1_im >>> 1) : x1_im;
                s1_c   <= tw_cos;
                s1_ns  <= tw_nsin;
            end
        end
    end

    // Full-precision products and rounded rotation.
    logic signed [MW-1:0] p_cr, p_ni, p_ci, p_nr;
    logic signed [PW-1:0] re_sum, im_sum;

    assign p_cr = MW'(s1_c)  * MW'(s1_x1r);
    assign p_ni = MW'(s1_ns) * MW'(s1_x1i);
    assign p_ci = MW'(s1_c)  * MW'(s1_x1i);
    assign p_nr = MW'(s1_ns) * MW'(s1_x1r);

    assign re_sum = PW'(p_cr) - PW'(p_ni) + RND;
    assign im_sum = PW'(p_ci) + PW'(p_nr) + RND;

    // Stage 2: register the rotated value and the delayed top operand.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rot_valid <= 1'b0;
            rot_re    <= '0;
            rot_im    <= '0;
            x0_re_d   <= '0;
            x0_im_d   <= '0;
        end else begin
            rot_valid <= s1_valid;
            if (s1_valid) begin
                rot_re  <= re_sum[PW-1:FRAC];
                rot_im  <= im_sum[PW-1:FRAC];
                x0_re_d <= s1_x0r;
                x0_im_d <= s1_x0i;
            end
        end
    end

    // R5: nothing enters the pipe without an accepted beat.
    a_r5_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> !s1_valid);

    // R2: the capture stage always advances one cycle later.
    a_r2_stage_chain: assert property (@(posedge clk) disable iff (!rst_n)
        s1_valid |=> rot_valid);

endmodule

// File: rtl/bfp_addsub.sv
module bfp_addsub #(
    parameter int DW         = 16,
    parameter int AW         = DW + 3,
    parameter int RISK_SHIFT = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic signed [AW-1:0] rot_re,
    input  logic signed [AW-1:0] rot_im,
    input  logic signed [DW-1:0] x0_re,
    input  logic signed [DW-1:0] x0_im,
    output logic                 out_valid,
    output logic signed [DW-1:0] y0_re,
    output logic signed [DW-1:0] y0_im,
    output logic signed [DW-1:0] y1_re,
    output logic signed [DW-1:0] y1_im,
    output logic                 risk_hit
);

    localparam int SW    = AW + 1;
    localparam int LANES = 4;
    localparam logic signed [SW-1:0] HI    = SW'((1 << (DW - 1)) - 1);
    localparam logic signed [SW-1:0] LO    = -HI - SW'(1);
    localparam logic signed [DW-1:0] LIMIT = DW'(1 << (DW - 1 - RISK_SHIFT));

    function automatic logic signed [DW-1:0] clip(input logic signed [SW-1:0] v);
        if (v > HI)      return HI[DW-1:0];
        else if (v < LO) return LO[DW-1:0];
        else             return v[DW-1:0];
    endfunction

    logic signed [SW-1:0] xr_w, xi_w, ar_w, ai_w;
    logic signed [SW-1:0] raw  [LANES];
    logic signed [DW-1:0] lane [LANES];
    logic [LANES-1:0]     near;

    assign xr_w = SW'(x0_re);
    assign xi_w = SW'(x0_im);
    assign ar_w = SW'(rot_re);
    assign ai_w = SW'(rot_im);

    assign raw[0] = xr_w + ar_w;
    assign raw[1] = xi_w + ai_w;
    assign raw[2] = xr_w - ar_w;
    assign raw[3] = xi_w - ai_w;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane[g] = clip(raw[g]);
        assign near[g] = (lane[g] >= LIMIT) || (lane[g] <= -LIMIT);
    end

    assign risk_hit = in_valid && (|near);

    // Stage 3: output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            y0_re     <= '0;
            y0_im     <= '0;
            y1_re     <= '0;
            y1_im     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                y0_re <= lane[0];
                y0_im <= lane[1];
                y1_re <= lane[2];
                y1_im <= lane[3];
            end
        end
    end

    // R2: the final stage follows its input one cycle later.
    a_r2_out_follows: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

endmodule

// File: rtl/bfp_butterfly.sv
module bfp_butterfly #(
    parameter int DW         = 16,
    parameter int EXPW       = 4,
    parameter int RISK_SHIFT = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 stage_start,
    input  logic                 scale_in,
    input  logic                 valid_in,
    input  logic signed [DW-1:0] x0_re,
    input  logic signed [DW-1:0] x0_im,
    input  logic signed [DW-1:0] x1_re,
    input  logic signed [DW-1:0] x1_im,
    input  logic signed [DW-1:0] tw_cos,
    input  logic signed [DW-1:0] tw_nsin,
    output logic                 valid_out,
    output logic signed [DW-1:0] y0_re,
    output logic signed [DW-1:0] y0_im,
    output logic signed [DW-1:0] y1_re,
    output logic signed [DW-1:0] y1_im,
    output logic                 headroom_risk,
    output logic [EXPW-1:0]      blk_exp
);

    localparam int AW = DW + 3;
    localparam logic signed [DW-1:0] LIMIT = DW'(1 << (DW - 1 - RISK_SHIFT));

    logic                 running, scale_mode, accept, risk_hit;
    logic                 rot_valid;
    logic signed [AW-1:0] rot_re, rot_im;
    logic signed [DW-1:0] x0_re_d, x0_im_d;

    assign accept = valid_in && running;

    bfp_stage_ctrl #(.EXPW(EXPW)) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .stage_start   (stage_start),
        .scale_in      (scale_in),
        .risk_hit      (risk_hit),
        .running       (running),
        .scale_mode    (scale_mode),
        .headroom_risk (headroom_risk),
        .blk_exp       (blk_exp)
    );

    bfp_rotate #(.DW(DW), .AW(AW)) u_rotate (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .scale_mode (scale_mode),
        .x0_re      (x0_re),
        .x0_im      (x0_im),
        .x1_re      (x1_re),
        .x1_im      (x1_im),
        .tw_cos     (tw_cos),
        .tw_nsin    (tw_nsin),
        .rot_valid  (rot_valid),
        .rot_re     (rot_re),
        .rot_im     (rot_im),
        .x0_re_d    (x0_re_d),
        .x0_im_d    (x0_im_d)
    );

    bfp_addsub #(.DW(DW), .AW(AW), .RISK_SHIFT(RISK_SHIFT)) u_addsub (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rot_valid),
        .rot_re    (rot_re),
        .rot_im    (rot_im),
        .x0_re     (x0_re_d),
        .x0_im     (x0_im_d),
        .out_valid (valid_out),
        .y0_re     (y0_re),
        .y0_im     (y0_im),
        .y1_re     (y1_re),
        .y1_im     (y1_im),
        .risk_hit  (risk_hit)
    );

    // R8: a large visible result is always accompanied by the flag.
    a_r8_flag_with_output: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_out && ((y0_re >= LIMIT) || (y0_re <= -LIMIT) ||
                       (y1_im >= LIMIT) || (y1_im <= -LIMIT))) |-> headroom_risk);

endmodule

// File: tb/test_bfp_butterfly.sv
`timescale 1ns/1ps
module test_bfp_butterfly;

    localparam int DW      = 16;
    localparam int EXPW    = 4;
    localparam int EXP_TOP = (1 << EXPW) - 1;
    localparam int LIM     = 8192;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, stage_start, scale_in, valid_in;
    logic signed [DW-1:0] x0_re, x0_im, x1_re, x1_im, tw_cos, tw_nsin;
    logic valid_out, headroom_risk;
    logic signed [DW-1:0] y0_re, y0_im, y1_re, y1_im;
    logic [EXPW-1:0] blk_exp;

    bfp_butterfly #(.DW(DW), .EXPW(EXPW), .RISK_SHIFT(2)) i_bfp_butterfly (
        .clk(clk), .rst_n(rst_n), .stage_start(stage_start), .scale_in(scale_in),
        .valid_in(valid_in), .x0_re(x0_re), .x0_im(x0_im), .x1_re(x1_re),
        .x1_im(x1_im), .tw_cos(tw_cos), .tw_nsin(tw_nsin), .valid_out(valid_out),
        .y0_re(y0_re), .y0_im(y0_im), .y1_re(y1_re), .y1_im(y1_im),
        .headroom_risk(headroom_risk), .blk_exp(blk_exp)
    );

    int checks = 0, fails = 0, wr = 0, rd = 0, seen = 0, cyc = 0;
    bit done = 1'b0;
    int e0r[4096], e0i[4096], e1r[4096], e1i[4096];
    string etag[4096];
    bit model_risk = 1'b0, model_scale = 1'b0, model_run = 1'b0;
    int model_exp = 0;

    task automatic chk(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int rnd15(input longint p);
        longint t;
        t = (p + 64'sd16384) >>> 15;
        return int'(t);
    endfunction

    function automatic int clampv(input int v);
        if (v > 32767)  return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic bit big(input int v);
        return (v >= LIM) || (v <= -LIM);
    endfunction

    function automatic int rv(input int lim);
        return int'($urandom_range(0, 2 * lim - 1)) - lim;
    endfunction

    task automatic push(input string tag, input int a0r, input int a0i,
                        input int a1r, input int a1i, input int c, input int ns);
        int p0r, p0i, p1r, p1i, ar, ai;
        @(negedge clk);
        x0_re = 16'(a0r); x0_im = 16'(a0i); x1_re = 16'(a1r); x1_im = 16'(a1i);
        tw_cos = 16'(c); tw_nsin = 16'(ns);
        scale_in = 1'($urandom_range(0, 1));   // R6: ignored inside a pass
        valid_in = 1'b1;
        if (model_run) begin
            p0r = model_scale ? (a0r >>> 1) : a0r;
            p0i = model_scale ? (a0i >>> 1) : a0i;
            p1r = model_scale ? (a1r >>> 1) : a1r;
            p1i = model_scale ? (a1i >>> 1) : a1i;
            ar = rnd15(longint'(c) * p1r - longint'(ns) * p1i);
            ai = rnd15(longint'(c) * p1i + longint'(ns) * p1r);
            e0r[wr] = clampv(p0r + ar);
            e0i[wr] = clampv(p0i + ai);
            e1r[wr] = clampv(p0r - ar);
            e1i[wr] = clampv(p0i - ai);
            etag[wr] = tag;
            wr++;
        end
    endtask

    task automatic idle_n(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            valid_in = 1'b0;
            scale_in = 1'b0;
        end
    endtask

    task automatic begin_stage(input bit s);
        idle_n(5);
        @(negedge clk);
        stage_start = 1'b1;
        scale_in = s;
        @(negedge clk);
        stage_start = 1'b0;
        scale_in = 1'b0;
        model_run = 1'b1;
        model_scale = s;
        model_risk = 1'b0;
        if (s && model_exp < EXP_TOP) model_exp++;
        chk("R9 flag cleared at pass start", int'(headroom_risk), 0);
        chk("R10 block exponent", int'(blk_exp), model_exp);
    endtask

    // Output monitor, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && valid_out) begin
            seen++;
            if (rd >= wr) begin
                chk("R5 unexpected valid_out", 1, 0);
            end else begin
                chk({etag[rd], " y0_re"}, int'(y0_re), e0r[rd]);
                chk({etag[rd], " y0_im"}, int'(y0_im), e0i[rd]);
                chk({etag[rd], " y1_re"}, int'(y1_re), e1r[rd]);
                chk({etag[rd], " y1_im"}, int'(y1_im), e1i[rd]);
                if (big(e0r[rd]) || big(e0i[rd]) || big(e1r[rd]) || big(e1i[rd]))
                    model_risk = 1'b1;
                chk("R8 flag with output", int'(headroom_risk), int'(model_risk));
                rd++;
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !done) begin
            fails++;
            $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; stage_start = 1'b0; scale_in = 1'b0; valid_in = 1'b0;
        x0_re = '0; x0_im = '0; x1_re = '0; x1_im = '0; tw_cos = '0; tw_nsin = '0;
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        chk("R1 valid_out in reset", int'(valid_out), 0);
        chk("R1 y0_re in reset", int'(y0_re), 0);
        chk("R1 y1_im in reset", int'(y1_im), 0);
        chk("R1 flag in reset", int'(headroom_risk), 0);
        chk("R1 exponent in reset", int'(blk_exp), 0);
        rst_n = 1'b1;

        // R5: beats before the first pass are dropped.
        for (int k = 0; k < 3; k++) push("R5", rv(32768), rv(32768), rv(32768), rv(32768), rv(32768), rv(32768));
        idle_n(6);
        chk("R5 no output while idle", seen, 0);

        begin_stage(1'b0);

        // R2: exact three-edge latency.
        push("R2", 1000, -2000, 3000, 4000, 23170, -23170);
        @(negedge clk); valid_in = 1'b0;
        chk("R2 latency edge1", int'(valid_out), 0);
        @(negedge clk);
        chk("R2 latency edge2", int'(valid_out), 0);
        @(negedge clk);
        chk("R2 latency edge3", int'(valid_out), 1);
        @(negedge clk);
        chk("R2 single pulse", int'(valid_out), 0);

        // R6: scale_in toggling inside an unscaled pass has no effect.
        push("R6", 3, -5, 7, 9, 32767, 0);
        push("R6", -7, 11, -13, 5, 16384, -16384);
        // R4: clipping corners.
        push("R4", 32767, 32767, 32767, 32767, 32767, 0);
        push("R4", -32768, -32768, -32768, 0, -32768, 0);
        push("R4", 0, 0, -32768, -32768, -32768, -32768);
        push("R3", 0, 0, 16384, 0, 32767, 0);
        idle_n(6);

        // R8: small results keep the flag low, one large result sets it.
        begin_stage(1'b0);
        for (int k = 0; k < 20; k++) push("R8", rv(2000), rv(2000), rv(2000), rv(2000), rv(32768), rv(32768));
        idle_n(5);
        chk("R8 flag low after small results", int'(headroom_risk), 0);
        push("R8", 8192, 0, 0, 0, 0, 0);
        for (int k = 0; k < 10; k++) push("R8", rv(2000), rv(2000), rv(2000), rv(2000), rv(32768), rv(32768));
        idle_n(5);
        chk("R8 flag sticky", int'(headroom_risk), 1);

        // R9 and R7: halved pass with random traffic and gaps.
        begin_stage(1'b1);
        push("R7", -1, 1, -32768, 32767, 32767, -32768);
        for (int k = 0; k < 300; k++) begin
            if ($urandom_range(0, 3) == 0) idle_n(1);
            push("R7", rv(32768), rv(32768), rv(32768), rv(32768), rv(32768), rv(32768));
        end
        idle_n(6);

        // R3: unhalved pass, back-to-back full-range beats.
        begin_stage(1'b0);
        for (int k = 0; k < 400; k++)
            push("R3", rv(32768), rv(32768), rv(32768), rv(32768), rv(32768), rv(32768));
        idle_n(6);

        // R10: exponent saturation.
        for (int k = 0; k < EXP_TOP + 2; k++) begin
            begin_stage(1'b1);
            push("R7", rv(32768), rv(32768), rv(32768), rv(32768), rv(32768), rv(32768));
        end
        begin_stage(1'b0);
        chk("R10 exponent saturated", int'(blk_exp), EXP_TOP);

        idle_n(8);
        chk("R2 every beat produced once", rd, wr);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule